// File: doc/BRIEF.md
# Latched Word Transmit Sequencer

This block takes a parallel data word through a level-sensitive input buffer and sends it as a framed serial transfer, one bit per cycle of a free-running link clock. Each frame is ten clock periods long. It opens with two sync periods, a 1 followed by a 0, and the eight data bits follow, least significant first. A frame-active strobe stays high for exactly the frame's length, so the receiving side always knows which cycles carry a frame.

Two operating modes are selectable. In user-timed mode, the falling edge of the latch enable starts a frame, and a second fall before the frame ends abandons it. The strobe then drops for a single clock, and a fresh frame carries the newly held word. In free-running mode, the block repeats frames on its own with a fixed twenty-clock period. The latch enable then only decides whether the buffer follows the bus or holds its value.

Top module: `word_tx_seq`

## Requirements
- R1: `free_run` = 1 selects free-running operation and `free_run` = 0 selects user-timed operation. The mode is sampled on every clock.
- R2: On each rising clock edge where `lat_en` = 1, the input buffer loads `bus_in`. While `lat_en` = 0, the buffer keeps its value. A frame always carries the buffer contents present at the edge where it starts.
- R3: In user-timed mode, no frame begins while `lat_en` stays at one level. A frame starts at the first clock edge that samples `lat_en` low after it was sampled high, and `frame_act` is high in the cycle that follows that edge.
- R4: A frame holds `frame_act` high for exactly 10 consecutive cycles. `ser_bit` carries 1, then 0, then data bits 0 through 7 in that order. Whenever `frame_act` is low, `ser_bit` is 0.
- R5: Raising `lat_en` and changing `bus_in` while a frame is being sent leaves every bit of that frame unchanged.
- R6: In user-timed mode, a new `lat_en` fall while a frame is active ends that frame. `frame_act` is then low for exactly one cycle, and a complete new frame follows that carries the buffer contents at the fall.
- R7: In free-running mode, the first frame begins in the tenth cycle after reset is released. After that, frames begin every 20 cycles, each followed by 10 idle cycles.
- R8: In free-running mode, `lat_en` edges neither start nor cut short a frame.
- R9: Reset (`rst` = 1, synchronous) forces `frame_act` and `ser_bit` low, clears the buffer to zero, and cancels a pending restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running link clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 8 | Parallel data word |
| lat_en | input | 1 | Input buffer enable: high follows the bus, low holds; a fall starts a frame in user-timed mode |
| free_run | input | 1 | Mode select: 1 free-running, 0 user-timed |
| ser_bit | output | 1 | Serial link bit |
| frame_act | output | 1 | High during the cycles of a frame |

## Verification
In user-timed mode, the bench sends words with asymmetric bit patterns (A5, 3C, 5A) so that a swapped bit order, a shifted sync header or an off-by-one slot shows up as a wrong bit. It raises the enable mid-frame and leaves it high, which separates recapture (the frame is undisturbed and the next frame carries the new word) from a false abort. It then drops the enable mid-frame, which must produce the one-cycle gap and a full restart with the new word. In free-running mode, enable falls placed inside both idle and active windows must shift neither the twenty-cycle cadence nor the frame contents. A first frame of zero after reset shows the buffer was cleared, and a reset applied during the gap shows the restart is cancelled.

// File: rtl/word_tx_pkg.sv
package word_tx_pkg;

    localparam int DEF_WORD_W   = 8;
    localparam int DEF_SYNC_LEN = 2;
    localparam int DEF_PERIOD   = 20;

    typedef enum logic [1:0] {
        LNK_IDLE = 2'd0,
        LNK_SEND = 2'd1,
        LNK_GAP  = 2'd2
    } lnk_state_e;

    // Sync header pattern: a single leading one, zeros after it.
    function automatic logic sync_bit(input int unsigned idx);
        return (idx == 0);
    endfunction

endpackage

// File: rtl/wtx_in_latch.sv
module wtx_in_latch #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] bus_in,
    input  logic              lat_en,
    output logic [WORD_W-1:0] held_word,
    output logic              fall_evt
);

    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_word <= '0;
            en_q      <= 1'b0;
        end else begin
            en_q <= lat_en;
            if (lat_en) begin
                held_word <= bus_in;
            end
        end
    end

    assign fall_evt = en_q & ~lat_en;

    // R2: buffer holds while the enable is low
    p_hold_low_r2: assert property (@(posedge clk) disable iff (rst)
        !lat_en |=> held_word == $past(held_word));

    // R2: buffer follows the bus while the enable is high
    p_follow_high_r2: assert property (@(posedge clk) disable iff (rst)
        lat_en |=> held_word == $past(bus_in));

endmodule

// File: rtl/wtx_frame_ctrl.sv
module wtx_frame_ctrl
    import word_tx_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int SYNC_LEN = 2,
    parameter int PERIOD   = 20,
    localparam int FRAME_LEN = SYNC_LEN + WORD_W,
    localparam int SLOT_W    = $clog2(FRAME_LEN),
    localparam int IDLE_LEN  = PERIOD - FRAME_LEN,
    localparam int CNT_W     = $clog2(IDLE_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              free_run,
    input  logic              fall_evt,
    input  logic [WORD_W-1:0] held_word,
    output lnk_state_e        state_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [WORD_W-1:0] word_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0]  LAST_IDLE = CNT_W'(IDLE_LEN - 1);

    lnk_state_e        state;
    logic [SLOT_W-1:0] slot;
    logic [CNT_W-1:0]  idle_cnt;
    logic [WORD_W-1:0] word_r;
    logic              user_fall;

    assign user_fall = fall_evt & ~free_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LNK_IDLE;
            slot     <= '0;
            idle_cnt <= '0;
            word_r   <= '0;
        end else begin
            unique case (state)
                LNK_IDLE: begin
                    slot <= '0;
                    if (free_run) begin
                        if (idle_cnt == LAST_IDLE) begin
                            state    <= LNK_SEND;
                            word_r   <= held_word;
                            idle_cnt <= '0;
                        end else begin
                            idle_cnt <= idle_cnt + 1'b1;
                        end
                    end else begin
                        idle_cnt <= '0;
                        if (fall_evt) begin
                            state  <= LNK_SEND;
                            word_r <= held_word;
                        end
                    end
                end
                LNK_SEND: begin
                    if (user_fall) begin
                        state  <= LNK_GAP;
                        word_r <= held_word;
                        slot   <= '0;
                    end else if (slot == LAST_SLOT) begin
                        state    <= LNK_IDLE;
                        slot     <= '0;
                        idle_cnt <= '0;
                    end else begin
                        slot <= slot + 1'b1;
                    end
                end
                LNK_GAP: begin
                    state <= LNK_SEND;
                    slot  <= '0;
                end
                default: begin
                    state <= LNK_IDLE;
                    slot  <= '0;
                end
            endcase
        end
    end

    assign state_o = state;
    assign slot_o  = slot;
    assign word_o  = word_r;

    // R4: slots advance one per clock while a frame runs undisturbed
    p_slot_step_r4: assert property (@(posedge clk) disable iff (rst)
        (state == LNK_SEND && slot != LAST_SLOT && !user_fall)
        |=> (state == LNK_SEND && slot == $past(slot) + 1'b1));

    // R6: the abort gap lasts exactly one clock, then slot zero
    p_gap_once_r6: assert property (@(posedge clk) disable iff (rst)
        state == LNK_GAP |=> (state == LNK_SEND && slot == '0));

    // R3: user-timed idle line stays idle without an enable fall
    p_no_start_r3: assert property (@(posedge clk) disable iff (rst)
        (!free_run && state == LNK_IDLE && !fall_evt) |=> state == LNK_IDLE);

    // R8: free-running frames are never aborted
    p_no_abort_r8: assert property (@(posedge clk) disable iff (rst)
        (free_run && state == LNK_SEND) |=> state != LNK_GAP);

    // R7: free-running idle window is not cut short
    p_idle_window_r7: assert property (@(posedge clk) disable iff (rst)
        (free_run && state == LNK_IDLE && idle_cnt != LAST_IDLE)
        |=> state == LNK_IDLE);

endmodule

// File: rtl/wtx_bit_sel.sv
module wtx_bit_sel
    import word_tx_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int SYNC_LEN = 2,
    localparam int FRAME_LEN = SYNC_LEN + WORD_W,
    localparam int SLOT_W    = $clog2(FRAME_LEN)
) (
    input  lnk_state_e        state,
    input  logic [SLOT_W-1:0] slot,
    input  logic [WORD_W-1:0] word,
    output logic              ser_bit,
    output logic              frame_act
);

    logic hdr_bit;
    logic dat_bit;

    always_comb begin
        hdr_bit = 1'b0;
        for (int h = 0; h < SYNC_LEN; h++) begin
            if (slot == SLOT_W'(h)) begin
                hdr_bit = sync_bit(h);
            end
        end
    end

    always_comb begin
        dat_bit = 1'b0;
        for (int k = 0; k < WORD_W; k++) begin
            if (slot == SLOT_W'(k + SYNC_LEN)) begin
                dat_bit = word[k];
            end
        end
    end

    assign frame_act = (state == LNK_SEND);
    assign ser_bit   = frame_act & ((slot < SLOT_W'(SYNC_LEN)) ? hdr_bit : dat_bit);

endmodule

// File: rtl/word_tx_seq.sv
module word_tx_seq
    import word_tx_pkg::*;
#(
    parameter int WORD_W   = DEF_WORD_W,
    parameter int SYNC_LEN = DEF_SYNC_LEN,
    parameter int PERIOD   = DEF_PERIOD,
    localparam int FRAME_LEN = SYNC_LEN + WORD_W,
    localparam int SLOT_W    = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] bus_in,
    input  logic              lat_en,
    input  logic              free_run,
    output logic              ser_bit,
    output logic              frame_act
);

    logic [WORD_W-1:0] held_word;
    logic              fall_evt;
    lnk_state_e        state;
    logic [SLOT_W-1:0] slot;
    logic [WORD_W-1:0] word;

    wtx_in_latch #(.WORD_W(WORD_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .bus_in    (bus_in),
        .lat_en    (lat_en),
        .held_word (held_word),
        .fall_evt  (fall_evt)
    );

    wtx_frame_ctrl #(
        .WORD_W   (WORD_W),
        .SYNC_LEN (SYNC_LEN),
        .PERIOD   (PERIOD)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .free_run  (free_run),
        .fall_evt  (fall_evt),
        .held_word (held_word),
        .state_o   (state),
        .slot_o    (slot),
        .word_o    (word)
    );

    wtx_bit_sel #(
        .WORD_W   (WORD_W),
        .SYNC_LEN (SYNC_LEN)
    ) u_sel (
        .state     (state),
        .slot      (slot),
        .word      (word),
        .ser_bit   (ser_bit),
        .frame_act (frame_act)
    );

    // R4: the line is quiet outside frames
    p_quiet_line_r4: assert property (@(posedge clk) disable iff (rst)
        !frame_act |-> !ser_bit);

    // R4: every frame opens with a one
    p_head_one_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_act && !$past(frame_act)) |-> ser_bit);

    // R9: reset leaves the link idle on the next cycle
    p_reset_idle_r9: assert property (@(posedge clk)
        rst |=> !frame_act);

endmodule

// File: tb/tb_word_tx_seq.sv
module tb_word_tx_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic       lat_en = 1'b0;
    logic       free_run = 1'b0;
    logic       ser_bit;
    logic       frame_act;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    word_tx_seq dut (
        .clk       (clk),
        .rst       (rst),
        .bus_in    (bus_in),
        .lat_en    (lat_en),
        .free_run  (free_run),
        .ser_bit   (ser_bit),
        .frame_act (frame_act)
    );

    function automatic logic exp_bit(input logic [7:0] w, input int s);
        if (s == 0) return 1'b1;
        if (s == 1) return 1'b0;
        return w[s-2];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Current negedge is slot 0; returns at the first cycle after the frame.
    task automatic expect_frame(input logic [7:0] w, input string req);
        for (int i = 0; i < 10; i++) begin
            chk({req, " frame_act"}, frame_act, 1'b1);
            chk({req, " ser_bit"}, ser_bit, exp_bit(w, i));
            @(negedge clk);
        end
        chk({req, " frame end"}, frame_act, 1'b0);
    endtask

    task automatic expect_idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk({req, " idle frame_act"}, frame_act, 1'b0);
            chk({req, " idle ser_bit"}, ser_bit, 1'b0);
            @(negedge clk);
        end
    endtask

    task automatic apply_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1; free_run = mode; lat_en = 1'b0; bus_in = 8'h00;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // R9: outputs idle while reset is held, even with the enable high
    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; lat_en = 1'b1; bus_in = 8'hFF; free_run = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 reset frame_act", frame_act, 1'b0);
            chk("R9 reset ser_bit", ser_bit, 1'b0);
        end
        lat_en = 1'b0;
    endtask

    // R1 R3 R4: user-timed start on the enable fall, header and LSB-first data
    task automatic t_sync_basic;
        apply_reset(1'b0);
        lat_en = 1'b1; bus_in = 8'h11;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R3 enable high no frame", frame_act, 1'b0);
            bus_in = (i == 3) ? 8'hA5 : 8'(i + 2);
        end
        @(negedge clk);
        lat_en = 1'b0;
        @(negedge clk);
        expect_frame(8'hA5, "R4 R1 sync A5");
        for (int i = 0; i < 6; i++) begin
            chk("R3 enable low no frame", frame_act, 1'b0);
            bus_in = 8'(8'h40 + i);
            @(negedge clk);
        end
    endtask

    // R5 R2: recapture during a frame does not disturb it; next frame uses it
    task automatic t_recapture;
        apply_reset(1'b0);
        lat_en = 1'b1; bus_in = 8'h3C;
        @(negedge clk);
        lat_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            chk("R5 frame_act", frame_act, 1'b1);
            chk("R5 ser_bit", ser_bit, exp_bit(8'h3C, i));
            if (i == 2) begin lat_en = 1'b1; bus_in = 8'hC3; end
            @(negedge clk);
        end
        chk("R5 frame end", frame_act, 1'b0);
        lat_en = 1'b0;
        @(negedge clk);
        expect_frame(8'hC3, "R2 recaptured C3");
    endtask

    // R6: mid-frame fall gives one idle cycle then a full new frame
    task automatic t_abort;
        apply_reset(1'b0);
        lat_en = 1'b1; bus_in = 8'h5A;
        @(negedge clk);
        lat_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            chk("R6 pre-abort frame_act", frame_act, 1'b1);
            chk("R6 pre-abort ser_bit", ser_bit, exp_bit(8'h5A, i));
            if (i == 2) begin lat_en = 1'b1; bus_in = 8'h96; end
            if (i == 4) lat_en = 1'b0;
            @(negedge clk);
        end
        chk("R6 gap frame_act", frame_act, 1'b0);
        chk("R6 gap ser_bit", ser_bit, 1'b0);
        @(negedge clk);
        expect_frame(8'h96, "R6 restart 96");
    endtask

    // R9: reset during the abort gap cancels the restart
    task automatic t_reset_cancel;
        apply_reset(1'b0);
        lat_en = 1'b1; bus_in = 8'h77;
        @(negedge clk);
        lat_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        lat_en = 1'b1;
        @(negedge clk);
        lat_en = 1'b0;
        @(negedge clk);
        chk("R9 gap before reset", frame_act, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_idle(12, "R9 cancelled restart");
    endtask

    // R1 R7 R8 R9: free-running cadence, cleared buffer, enable edges ignored
    task automatic t_async;
        apply_reset(1'b1);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            chk("R7 first idle window", frame_act, 1'b0);
        end
        @(negedge clk);
        expect_frame(8'h00, "R9 cleared buffer");
        for (int i = 0; i < 10; i++) begin
            chk("R8 idle despite enable fall", frame_act, 1'b0);
            if (i == 1) begin lat_en = 1'b1; bus_in = 8'hE7; end
            if (i == 3) lat_en = 1'b0;
            if (i == 4) bus_in = 8'h11;
            @(negedge clk);
        end
        for (int i = 0; i < 10; i++) begin
            chk("R8 frame_act no abort", frame_act, 1'b1);
            chk("R8 ser_bit E7", ser_bit, exp_bit(8'hE7, i));
            if (i == 2) begin lat_en = 1'b1; bus_in = 8'h29; end
            if (i == 5) lat_en = 1'b0;
            @(negedge clk);
        end
        expect_idle(10, "R7 idle window");
        expect_frame(8'h29, "R7 R1 periodic 29");
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sync_basic();
        t_recapture();
        t_abort();
        t_reset_cancel();
        t_async();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule